// File: doc/BRIEF.md
# Tape Frame / Bus Word Packer

This block sits between a tape data channel that moves 8-bit frames and a bus side that moves 16-bit words. On a read it gathers incoming frames into words; on a write it breaks words into frames. Two packing formats are supported. In the standard format a word holds two whole frames. In the core-dump format a word holds four frames, and only the low nibble of each frame is used. Either format can run with the tape moving forward or backward. Backward runs mirror the position order inside each word.

A record begins with a one-cycle `start` pulse. This pulse latches the format, the direction, whether the record is a read or a write, and the requested transfer count. Frames and words then move over separate valid/ready handshakes. A last flag on the frame channel (reads) or the word channel (writes) closes the record. A partial word left at that point is completed with zero frames. When the record is closed the block holds a transfer count and a count-error flag until the next record starts.

Top module: `tape_word_packer`

## Requirements
- R1: After reset every valid and ready output is low, and `busy`, `rec_done`, `xfer_cnt` and `cnt_err` are zero.
- R2: In a standard forward read, the first frame of each pair lands in word bits 7:0 and the second in bits 15:8.
- R3: In a core-dump forward read, four frames make one word. The low nibble of each frame goes into bits 3:0, 7:4, 11:8 and 15:12 in arrival order, and the upper nibble of each frame is discarded.
- R4: In a reverse read, the first frame to arrive takes the most significant position (bits 15:8 in standard, 15:12 in core-dump), and later frames fill the positions below it.
- R5: A frame carrying the last flag closes the current word even if the word is incomplete. Unfilled positions read as zero, and only that word has `rd_wrd_last` set.
- R6: A standard write sends each word as two frames, bits 7:0 then 15:8 when forward and 15:8 then 7:0 when reverse. `wr_frm_last` is set only on the final frame of the word flagged last.
- R7: A core-dump write sends each word as four frames. Each frame holds one nibble in bits 3:0 with bits 7:4 zero. Forward order starts at bits 3:0 and reverse order starts at bits 15:12.
- R8: At record close, `xfer_cnt` equals the number of frames moved in standard format, or (frames+1)/2 rounded down in core-dump format.
- R9: A read whose `req_cnt` exceeds the final `xfer_cnt` sets `cnt_err`. Equality or a smaller request leaves it clear, and writes never set it.
- R10: Format, direction and read/write are sampled only at `start` while idle. Changes to the configuration inputs, or further `start` pulses during a record, have no effect on that record.
- R11: A valid output holds its data and last flag stable until ready is seen. `rd_frm_ready` stays low while a finished word waits on the word output.
- R12: On the clock edge that transfers the record's last frame, `busy` falls and `rec_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a record; samples configuration when idle |
| cfg_core | input | 1 | 1 = core-dump format, 0 = standard |
| cfg_rev | input | 1 | 1 = reverse tape direction |
| cfg_write | input | 1 | 1 = write (words to frames), 0 = read |
| req_cnt | input | CNT_W | Requested transfer count for the error compare |
| rd_frm_valid | input | 1 | Read: frame valid |
| rd_frm_ready | output | 1 | Read: frame accepted |
| rd_frm_data | input | 8 | Read: frame value |
| rd_frm_last | input | 1 | Read: final frame of the record |
| rd_wrd_valid | output | 1 | Read: word valid |
| rd_wrd_ready | input | 1 | Read: word taken |
| rd_wrd_data | output | 16 | Read: assembled word |
| rd_wrd_last | output | 1 | Read: final word of the record |
| wr_wrd_valid | input | 1 | Write: word valid |
| wr_wrd_ready | output | 1 | Write: word accepted |
| wr_wrd_data | input | 16 | Write: word value |
| wr_wrd_last | input | 1 | Write: final word of the record |
| wr_frm_valid | output | 1 | Write: frame valid |
| wr_frm_ready | input | 1 | Write: frame taken |
| wr_frm_data | output | 8 | Write: frame value |
| wr_frm_last | output | 1 | Write: final frame of the record |
| busy | output | 1 | A record is in progress |
| rec_done | output | 1 | Last record finished; count outputs valid |
| xfer_cnt | output | CNT_W | Transfer count of the last record |
| cnt_err | output | 1 | Read yielded fewer than requested |

## Verification
On every cycle, the embedded properties check that both output handshakes hold their data while stalled. They also check that core-dump write frames never carry upper-nibble bits, that the latched mode cannot move mid-record, that `busy` and `rec_done` are never both high, and that a count error never appears on a write. The actual placement of bytes and nibbles in each format and direction, the zero fill of a short final word, the rounding of the core-dump count and the compare against the requested count can only be shown by the directed scenarios. Those scenarios compare the words and frames seen at the ports with values worked out by hand.

// File: rtl/twp_pkg.sv
`timescale 1ns/1ps
package twp_pkg;
  localparam int FRM_W = 8;
  localparam int WRD_W = 16;

  // bit offset of position idx inside a word
  function automatic logic [3:0] slot_lsb(input logic core, input logic rev, input logic [1:0] idx);
    logic [3:0] fwd;
    fwd = core ? {idx, 2'b00} : {idx[0], 3'b000};
    return rev ? ((core ? 4'd12 : 4'd8) - fwd) : fwd;
  endfunction

  function automatic logic [1:0] last_slot(input logic core);
    return core ? 2'd3 : 2'd1;
  endfunction

  function automatic logic [FRM_W-1:0] frame_mask(input logic core);
    return core ? 8'h0F : 8'hFF;
  endfunction

  function automatic logic [31:0] xfer_of(input logic core, input logic [31:0] frames);
    return core ? ((frames + 32'd1) >> 1) : frames;
  endfunction
endpackage

// File: rtl/twp_ctl.sv
`timescale 1ns/1ps
module twp_ctl import twp_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_core,
  input  logic             cfg_rev,
  input  logic             cfg_write,
  input  logic [CNT_W-1:0] req_cnt,
  input  logic             step,
  input  logic             fin,
  output logic             active,
  output logic             mode_core,
  output logic             mode_rev,
  output logic             mode_wr,
  output logic             done,
  output logic             cnt_err,
  output logic [CNT_W-1:0] xfer_cnt
);
  logic [CNT_W-1:0] frames, req_q, end_count, end_xfer;
  logic launch;

  assign launch    = start && !active;
  assign end_count = frames + 1'b1;
  assign end_xfer  = CNT_W'(xfer_of(mode_core, 32'(end_count)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; mode_core <= 1'b0; mode_rev <= 1'b0; mode_wr <= 1'b0;
      done <= 1'b0; cnt_err <= 1'b0; xfer_cnt <= '0; frames <= '0; req_q <= '0;
    end else if (launch) begin
      active <= 1'b1; mode_core <= cfg_core; mode_rev <= cfg_rev; mode_wr <= cfg_write;
      req_q <= req_cnt; frames <= '0; done <= 1'b0; cnt_err <= 1'b0; xfer_cnt <= '0;
    end else if (active) begin
      if (step) frames <= end_count;
      if (fin) begin
        active   <= 1'b0;
        done     <= 1'b1;
        xfer_cnt <= end_xfer;
        cnt_err  <= !mode_wr && (req_q > end_xfer);
      end
    end
  end

  // R12
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(active && done));
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(mode_core) && $stable(mode_rev) && $stable(mode_wr)));
  // R9
  err_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_err |-> !mode_wr);
endmodule

// File: rtl/twp_rd_pack.sv
`timescale 1ns/1ps
module twp_rd_pack import twp_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             core,
  input  logic             rev,
  input  logic             fi_valid,
  input  logic [FRM_W-1:0] fi_data,
  input  logic             fi_last,
  output logic             fi_ready,
  output logic             wo_valid,
  output logic [WRD_W-1:0] wo_data,
  output logic             wo_last,
  input  logic             wo_ready,
  output logic             step,
  output logic             fin
);
  logic [1:0]       idx;
  logic [WRD_W-1:0] acc, merged;
  logic             take, close;

  assign fi_ready = en && !wo_valid;
  assign take     = fi_valid && fi_ready;
  assign merged   = acc | (WRD_W'(fi_data & frame_mask(core)) << slot_lsb(core, rev, idx));
  assign close    = take && (fi_last || idx == last_slot(core));
  assign step     = take;
  assign fin      = take && fi_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; acc <= '0; wo_valid <= 1'b0; wo_data <= '0; wo_last <= 1'b0;
    end else begin
      if (wo_valid && wo_ready) wo_valid <= 1'b0;
      if (close) begin
        wo_data  <= merged;
        wo_last  <= fi_last;
        wo_valid <= 1'b1;
        acc      <= '0;
        idx      <= '0;
      end else if (take) begin
        acc <= merged;
        idx <= idx + 2'd1;
      end
    end
  end

  // R11
  wo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wo_valid && !wo_ready) |=> (wo_valid && $stable(wo_data) && $stable(wo_last)));
endmodule

// File: rtl/twp_wr_unpack.sv
`timescale 1ns/1ps
module twp_wr_unpack import twp_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             core,
  input  logic             rev,
  input  logic             wi_valid,
  input  logic [WRD_W-1:0] wi_data,
  input  logic             wi_last,
  output logic             wi_ready,
  output logic             fo_valid,
  output logic [FRM_W-1:0] fo_data,
  output logic             fo_last,
  input  logic             fo_ready,
  output logic             step,
  output logic             fin
);
  logic [WRD_W-1:0] hold;
  logic             hold_last, busy_q, emit, at_end;
  logic [1:0]       idx;

  assign wi_ready = en && !busy_q;
  assign fo_valid = busy_q;
  assign fo_data  = FRM_W'(hold >> slot_lsb(core, rev, idx)) & frame_mask(core);
  assign at_end   = (idx == last_slot(core));
  assign fo_last  = hold_last && at_end;
  assign emit     = busy_q && fo_ready;
  assign step     = emit;
  assign fin      = emit && fo_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0; hold_last <= 1'b0; busy_q <= 1'b0; idx <= '0;
    end else if (wi_valid && wi_ready) begin
      hold <= wi_data; hold_last <= wi_last; busy_q <= 1'b1; idx <= '0;
    end else if (emit) begin
      if (at_end) busy_q <= 1'b0;
      else        idx <= idx + 2'd1;
    end
  end

  // R11
  fo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_valid && !fo_ready) |=> (fo_valid && $stable(fo_data) && $stable(fo_last)));
  // R7
  nibble_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_valid && core) |-> (fo_data[7:4] == 4'h0));
endmodule

// File: rtl/tape_word_packer.sv
`timescale 1ns/1ps
module tape_word_packer import twp_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_core,
  input  logic             cfg_rev,
  input  logic             cfg_write,
  input  logic [CNT_W-1:0] req_cnt,
  input  logic             rd_frm_valid,
  output logic             rd_frm_ready,
  input  logic [7:0]       rd_frm_data,
  input  logic             rd_frm_last,
  output logic             rd_wrd_valid,
  input  logic             rd_wrd_ready,
  output logic [15:0]      rd_wrd_data,
  output logic             rd_wrd_last,
  input  logic             wr_wrd_valid,
  output logic             wr_wrd_ready,
  input  logic [15:0]      wr_wrd_data,
  input  logic             wr_wrd_last,
  output logic             wr_frm_valid,
  input  logic             wr_frm_ready,
  output logic [7:0]       wr_frm_data,
  output logic             wr_frm_last,
  output logic             busy,
  output logic             rec_done,
  output logic [CNT_W-1:0] xfer_cnt,
  output logic             cnt_err
);
  logic active, m_core, m_rev, m_wr;
  logic rd_step, rd_fin, wr_step, wr_fin;

  twp_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_core(cfg_core), .cfg_rev(cfg_rev), .cfg_write(cfg_write), .req_cnt(req_cnt),
    .step(rd_step || wr_step), .fin(rd_fin || wr_fin),
    .active(active), .mode_core(m_core), .mode_rev(m_rev), .mode_wr(m_wr),
    .done(rec_done), .cnt_err(cnt_err), .xfer_cnt(xfer_cnt));

  twp_rd_pack u_rd (
    .clk(clk), .rst_n(rst_n), .en(active && !m_wr), .core(m_core), .rev(m_rev),
    .fi_valid(rd_frm_valid), .fi_data(rd_frm_data), .fi_last(rd_frm_last),
    .fi_ready(rd_frm_ready),
    .wo_valid(rd_wrd_valid), .wo_data(rd_wrd_data), .wo_last(rd_wrd_last),
    .wo_ready(rd_wrd_ready), .step(rd_step), .fin(rd_fin));

  twp_wr_unpack u_wr (
    .clk(clk), .rst_n(rst_n), .en(active && m_wr), .core(m_core), .rev(m_rev),
    .wi_valid(wr_wrd_valid), .wi_data(wr_wrd_data), .wi_last(wr_wrd_last),
    .wi_ready(wr_wrd_ready),
    .fo_valid(wr_frm_valid), .fo_data(wr_frm_data), .fo_last(wr_frm_last),
    .fo_ready(wr_frm_ready), .step(wr_step), .fin(wr_fin));

  assign busy = active;
endmodule

// File: tb/tb_tape_word_packer.sv
`timescale 1ns/1ps
module tb_tape_word_packer;
  localparam int CNT_W = 16;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, cfg_core = 1'b0, cfg_rev = 1'b0, cfg_write = 1'b0;
  logic [CNT_W-1:0] req_cnt = '0;
  logic rd_frm_valid = 1'b0, rd_frm_last = 1'b0, rd_wrd_ready = 1'b1;
  logic [7:0] rd_frm_data = '0;
  logic wr_wrd_valid = 1'b0, wr_wrd_last = 1'b0, wr_frm_ready = 1'b1;
  logic [15:0] wr_wrd_data = '0;
  logic rd_frm_ready, rd_wrd_valid, rd_wrd_last, wr_wrd_ready, wr_frm_valid, wr_frm_last;
  logic [15:0] rd_wrd_data;
  logic [7:0] wr_frm_data;
  logic busy, rec_done, cnt_err;
  logic [CNT_W-1:0] xfer_cnt;

  tape_word_packer #(.CNT_W(CNT_W)) dut (.*);

  int checks = 0, fails = 0;
  logic [16:0] rdq[$];
  logic [8:0]  wfq[$];

  always @(negedge clk) begin
    if (rd_wrd_valid && rd_wrd_ready) rdq.push_back({rd_wrd_last, rd_wrd_data});
    if (wr_frm_valid && wr_frm_ready) wfq.push_back({wr_frm_last, wr_frm_data});
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_xfer(input bit core, input int n);
    return core ? (n / 2 + n % 2) : n;
  endfunction

  task automatic begin_rec(input bit core, input bit rev, input bit wr, input int req);
    start = 1'b1; cfg_core = core; cfg_rev = rev; cfg_write = wr; req_cnt = CNT_W'(req);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic push_frame(input logic [7:0] d, input bit l);
    bit ok;
    rd_frm_valid = 1'b1; rd_frm_data = d; rd_frm_last = l;
    do begin @(negedge clk); ok = rd_frm_ready; @(posedge clk); #1; end while (!ok);
    rd_frm_valid = 1'b0; rd_frm_last = 1'b0;
  endtask

  task automatic push_word(input logic [15:0] d, input bit l);
    bit ok;
    wr_wrd_valid = 1'b1; wr_wrd_data = d; wr_wrd_last = l;
    do begin @(negedge clk); ok = wr_wrd_ready; @(posedge clk); #1; end while (!ok);
    wr_wrd_valid = 1'b0; wr_wrd_last = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pop_word(input string tag, input logic [15:0] d, input bit l);
    if (rdq.size() == 0) check_eq({tag, " word missing"}, 32'h0, {15'h0, l, d});
    else check_eq(tag, {15'h0, rdq.pop_front()}, {15'h0, l, d});
  endtask

  task automatic pop_frame(input string tag, input logic [7:0] d, input bit l);
    if (wfq.size() == 0) check_eq({tag, " frame missing"}, 32'h0, {23'h0, l, d});
    else check_eq(tag, {23'h0, wfq.pop_front()}, {23'h0, l, d});
  endtask

  task automatic end_state(input string tag, input int xfer, input bit err);
    check_eq({tag, " R8 xfer_cnt"}, 32'(xfer_cnt), xfer);
    check_eq({tag, " R9 cnt_err"}, {31'h0, cnt_err}, {31'h0, err});
    check_eq({tag, " R12 done"}, {30'h0, busy, rec_done}, 32'h1);
  endtask

  task automatic t_reset();
    settle(3);
    @(negedge clk);
    check_eq("R1 reset outputs",
      {22'h0, rd_frm_ready, rd_wrd_valid, wr_wrd_ready, wr_frm_valid, busy, rec_done, cnt_err, 3'b0},
      32'h0);
    check_eq("R1 reset count", 32'(xfer_cnt), 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    settle(1);
  endtask

  task automatic t_std_fwd_read();
    begin_rec(0, 0, 0, 4);
    push_frame(8'h11, 0); push_frame(8'h22, 0); push_frame(8'h33, 0); push_frame(8'h44, 1);
    check_eq("R12 busy falls with last frame", {30'h0, busy, rec_done}, 32'h1);
    settle(3);
    pop_word("R2 std fwd word0", 16'h2211, 0);
    pop_word("R2 std fwd word1", 16'h4433, 1);
    end_state("R2", exp_xfer(0, 4), 0);
  endtask

  task automatic t_core_fwd_read();
    begin_rec(1, 0, 0, 4);
    push_frame(8'hA1, 0); push_frame(8'hB2, 0); push_frame(8'hC3, 0);
    push_frame(8'hD4, 0); push_frame(8'hE5, 1);
    settle(3);
    pop_word("R3 core fwd word0", 16'h4321, 0);
    pop_word("R5 core fwd partial", 16'h0005, 1);
    end_state("R3 R9 short", exp_xfer(1, 5), 1);
  endtask

  task automatic t_std_rev_read();
    begin_rec(0, 1, 0, 2);
    push_frame(8'h11, 0); push_frame(8'h22, 0); push_frame(8'h33, 1);
    settle(3);
    pop_word("R4 std rev word0", 16'h1122, 0);
    pop_word("R5 std rev partial", 16'h3300, 1);
    end_state("R4", exp_xfer(0, 3), 0);
  endtask

  task automatic t_core_rev_read();
    begin_rec(1, 1, 0, 3);
    for (int i = 1; i <= 6; i++) push_frame(8'(8'hF0 | i), i == 6);
    settle(3);
    pop_word("R4 core rev word0", 16'h1234, 0);
    pop_word("R5 core rev partial", 16'h5600, 1);
    end_state("R4 R9 equal", exp_xfer(1, 6), 0);
  endtask

  task automatic t_std_writes();
    begin_rec(0, 0, 1, 100);
    push_word(16'hBEEF, 0); push_word(16'h1234, 1);
    settle(4);
    pop_frame("R6 std fwd f0", 8'hEF, 0); pop_frame("R6 std fwd f1", 8'hBE, 0);
    pop_frame("R6 std fwd f2", 8'h34, 0); pop_frame("R6 std fwd f3", 8'h12, 1);
    end_state("R6 R9 write", exp_xfer(0, 4), 0);
    begin_rec(0, 1, 1, 0);
    push_word(16'hBEEF, 1);
    settle(4);
    pop_frame("R6 std rev f0", 8'hBE, 0); pop_frame("R6 std rev f1", 8'hEF, 1);
    end_state("R6 rev", exp_xfer(0, 2), 0);
  endtask

  task automatic t_core_writes();
    begin_rec(1, 1, 1, 9);
    push_word(16'hA5C3, 1);
    settle(6);
    pop_frame("R7 core rev f0", 8'h0A, 0); pop_frame("R7 core rev f1", 8'h05, 0);
    pop_frame("R7 core rev f2", 8'h0C, 0); pop_frame("R7 core rev f3", 8'h03, 1);
    end_state("R7 rev", exp_xfer(1, 4), 0);
    begin_rec(1, 0, 1, 0);
    push_word(16'h1234, 1);
    settle(6);
    pop_frame("R7 core fwd f0", 8'h04, 0); pop_frame("R7 core fwd f1", 8'h03, 0);
    pop_frame("R7 core fwd f2", 8'h02, 0); pop_frame("R7 core fwd f3", 8'h01, 1);
    end_state("R7 fwd", exp_xfer(1, 4), 0);
  endtask

  task automatic t_latch();
    begin_rec(0, 0, 0, 2);
    start = 1'b1; cfg_core = 1'b1; cfg_rev = 1'b1; cfg_write = 1'b1; req_cnt = 16'd50;
    push_frame(8'h11, 0);
    start = 1'b0;
    @(negedge clk);
    check_eq("R10 write side stays closed", {31'h0, wr_wrd_ready}, 32'h0);
    @(posedge clk); #1;
    push_frame(8'h22, 1);
    settle(3);
    pop_word("R10 mode kept", 16'h2211, 1);
    end_state("R10", 2, 0);
    cfg_core = 1'b0; cfg_rev = 1'b0; cfg_write = 1'b0;
  endtask

  task automatic t_backpressure();
    begin_rec(0, 0, 0, 0);
    rd_wrd_ready = 1'b0;
    push_frame(8'h01, 0); push_frame(8'h02, 0);
    @(negedge clk);
    check_eq("R11 word held", {13'h0, rd_frm_ready, rd_wrd_valid, rd_wrd_last, rd_wrd_data},
             {13'h0, 1'b0, 1'b1, 1'b0, 16'h0201});
    repeat (3) @(negedge clk);
    check_eq("R11 word still held", {13'h0, rd_frm_ready, rd_wrd_valid, rd_wrd_last, rd_wrd_data},
             {13'h0, 1'b0, 1'b1, 1'b0, 16'h0201});
    @(posedge clk); #1;
    rd_wrd_ready = 1'b1;
    push_frame(8'h03, 1);
    settle(3);
    pop_word("R11 word0", 16'h0201, 0);
    pop_word("R11 word1", 16'h0003, 1);
    end_state("R11", 3, 0);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_std_fwd_read();
    t_core_fwd_read();
    t_std_rev_read();
    t_core_rev_read();
    t_std_writes();
    t_core_writes();
    t_latch();
    t_backpressure();
    check_eq("R5 no stray words", 32'(rdq.size()), 32'h0);
    check_eq("R6 no stray frames", 32'(wfq.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule